// File: doc/BRIEF.md
# Cache-Line Memory Transfer Sequencer

This block sits between a cache controller and a main memory whose data port is a quarter of a cache line wide. The cache hands it one line request with an operation code, up to two line addresses (the victim's and the refill's) and, when a write is involved, the whole 512-bit line. The sequencer then runs a memory beat per handshake until the transfer is complete, and pulses a completion signal. The cache never sees the individual beats.

A write-back cuts the stored line into four 128-bit beats, lowest slice first. A refill gathers four returned beats into one line, which stays on the read-line output until the next refill. A single request may combine both: the victim is written out first and the new line is read in after it, with one completion pulse at the end. Each memory beat uses a valid/ready handshake. An internal beat counter moves forward only on an accepted beat, so the memory can stall any beat for as long as it needs.

Top module: `line_xfer_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and `mem_valid` are 0 and `rd_line` is all zeros.
- R2: A request is taken when `busy` is 0, `req_valid` is 1 and `req_op` is not 2'b00. From the next cycle `busy` is 1, and requests presented while `busy` is 1 cause no memory beats.
- R3: A request with `req_op` = 2'b00 is not taken: `busy` stays 0 and no memory beat is issued.
- R4: A write (`req_op` bit 1 set) issues four beats with `mem_we` = 1, beat k (k = 0..3, beat 0 first) at address {victim address, k[1:0]} carrying line bits [128k+127:128k].
- R5: A read (`req_op` bit 0 set) issues four beats with `mem_we` = 0 at addresses {refill address, k[1:0]}, beat 0 first, and `mem_rdata` of beat k lands in `rd_line` bits [128k+127:128k].
- R6: With `req_op` = 2'b11, all four write beats complete before the first read beat, and there is one completion for the whole request.
- R7: A beat counts only when `mem_valid` and `mem_ready` are both 1. While `mem_ready` is 0, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R8: `done` is a one-cycle pulse in the cycle after the last beat is accepted. `busy` is 1 during that cycle and 0 in the next.
- R9: `rd_line` changes only through read beats, so a write-only request leaves it at its previous value.
- R10: Addresses, operation and line data are captured when the request is taken. Later changes on the request inputs do not alter the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line request present |
| req_op | input | 2 | Bit 1: write victim line, bit 0: read refill line |
| req_wb_addr | input | ADDR_W | Line address of the victim |
| req_fill_addr | input | ADDR_W | Line address of the refill |
| req_wdata | input | LINE_W | Victim line data |
| busy | output | 1 | Transfer in progress, new requests held off |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | LINE_W | Most recently refilled line |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W+2 | Beat address: line address with beat index below it |
| mem_wdata | output | BEAT_W | Write beat data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | BEAT_W | Read beat data, valid in the accepting cycle |

## Verification
The assertions check the cycle-local rules on every cycle: the outputs are held during a stalled beat, `done` is a single-cycle pulse that drops `busy`, a read beat is never followed by a write beat within one request, and taking or refusing a request moves `busy` correctly. The address and data of each beat, the order of beats across a combined request, the assembled refill line, and the fact that stray requests and late changes on the request inputs produce no effect can be shown only by the bench. It does this by comparing the observed beats against an expected queue under both free-flowing and randomly stalled memory.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_e;

  localparam logic [1:0] OP_NONE    = 2'b00;
  localparam logic [1:0] OP_READ    = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b10;
  localparam logic [1:0] OP_WB_FILL = 2'b11;
endpackage

// File: rtl/lxs_beat_counter.sv
module lxs_beat_counter #(
  parameter int NB    = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] cnt_d;

  assign last = (cnt == CNT_W'(NB - 1));

  always_comb begin
    cnt_d = cnt;
    if (step) cnt_d = last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt_d;
  end
endmodule

// File: rtl/lxs_ctrl.sv
module lxs_ctrl
  import lxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        mem_ready,
  input  logic        last_beat,
  output xfer_state_e state,
  output logic        accept,
  output logic        beat_fire
);
  xfer_state_e state_d;
  logic [1:0]  op_q;

  assign accept    = (state == ST_IDLE) && req_valid && (req_op != OP_NONE);
  assign beat_fire = ((state == ST_WRITE) || (state == ST_READ)) && mem_ready;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (accept) state_d = req_op[1] ? ST_WRITE : ST_READ;
      ST_WRITE: if (beat_fire && last_beat) state_d = op_q[0] ? ST_READ : ST_DONE;
      ST_READ:  if (beat_fire && last_beat) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_NONE;
    else if (accept) op_q <= req_op;
  end
endmodule

// File: rtl/lxs_line_pack.sv
module lxs_line_pack #(
  parameter int LINE_W = 512,
  parameter int BEAT_W = 128,
  parameter int NB     = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_line,
  input  logic [LINE_W-1:0] line_in,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic              capture,
  input  logic [BEAT_W-1:0] beat_rdata,
  output logic [BEAT_W-1:0] beat_wdata,
  output logic [LINE_W-1:0] line_out
);
  logic [BEAT_W-1:0] wslot_q [NB];
  logic [BEAT_W-1:0] rslot_q [NB];

  assign beat_wdata = wslot_q[beat_idx];

  for (genvar k = 0; k < NB; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wslot_q[k] <= '0;
      else if (load_line) wslot_q[k] <= line_in[k*BEAT_W +: BEAT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     rslot_q[k] <= '0;
      else if (capture && (beat_idx == CNT_W'(k)))    rslot_q[k] <= beat_rdata;
    end

    assign line_out[k*BEAT_W +: BEAT_W] = rslot_q[k];
  end
endmodule

// File: rtl/line_xfer_seq.sv
module line_xfer_seq
  import lxs_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int BEAT_W = 128,
  parameter int ADDR_W = 26,
  localparam int NB    = LINE_W / BEAT_W,
  localparam int CNT_W = $clog2(NB),
  localparam int MA_W  = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_wb_addr,
  input  logic [ADDR_W-1:0] req_fill_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [LINE_W-1:0] rd_line,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [BEAT_W-1:0] mem_rdata
);
  xfer_state_e      state;
  logic             accept;
  logic             beat_fire;
  logic             last_beat;
  logic [CNT_W-1:0] beat_idx;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [ADDR_W-1:0] fill_addr_q;
  logic             rd_capture;

  lxs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .mem_ready (mem_ready),
    .last_beat (last_beat),
    .state     (state),
    .accept    (accept),
    .beat_fire (beat_fire)
  );

  lxs_beat_counter #(.NB(NB), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (beat_fire),
    .cnt   (beat_idx),
    .last  (last_beat)
  );

  assign rd_capture = beat_fire && (state == ST_READ);

  lxs_line_pack #(.LINE_W(LINE_W), .BEAT_W(BEAT_W), .NB(NB), .CNT_W(CNT_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_line  (accept),
    .line_in    (req_wdata),
    .beat_idx   (beat_idx),
    .capture    (rd_capture),
    .beat_rdata (mem_rdata),
    .beat_wdata (mem_wdata),
    .line_out   (rd_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_addr_q   <= '0;
      fill_addr_q <= '0;
    end else if (accept) begin
      wb_addr_q   <= req_wb_addr;
      fill_addr_q <= req_fill_addr;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign mem_valid = (state == ST_WRITE) || (state == ST_READ);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = {(mem_we ? wb_addr_q : fill_addr_q), beat_idx};
endmodule

// File: rtl/line_xfer_seq_chk.sv
module line_xfer_seq_chk #(
  parameter int LINE_W = 512,
  parameter int BEAT_W = 128,
  parameter int ADDR_W = 26,
  parameter int MA_W   = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [MA_W-1:0]   mem_addr,
  input logic [BEAT_W-1:0] mem_wdata,
  input logic              mem_ready
);
  a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op != 2'b00) |=> (busy && !done));

  a_r2_beats_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  a_r3_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 2'b00) |=> !busy);

  a_r6_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |=> !(mem_valid && mem_we));

  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !mem_valid));
endmodule

bind line_xfer_seq line_xfer_seq_chk #(
  .LINE_W (LINE_W),
  .BEAT_W (BEAT_W),
  .ADDR_W (ADDR_W),
  .MA_W   (MA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .busy      (busy),
  .done      (done),
  .mem_valid (mem_valid),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/line_xfer_seq_bench.sv
module line_xfer_seq_bench;
  localparam int LW  = 512;
  localparam int BW  = 128;
  localparam int AW  = 26;
  localparam int NB  = 4;
  localparam int MAW = 28;

  typedef struct packed {
    logic [MAW-1:0] addr;
    logic           we;
    logic [BW-1:0]  data;
  } beat_t;

  logic           clk;
  logic           rst_n;
  logic           req_valid;
  logic [1:0]     req_op;
  logic [AW-1:0]  req_wb_addr;
  logic [AW-1:0]  req_fill_addr;
  logic [LW-1:0]  req_wdata;
  logic           busy;
  logic           done;
  logic [LW-1:0]  rd_line;
  logic           mem_valid;
  logic           mem_we;
  logic [MAW-1:0] mem_addr;
  logic [BW-1:0]  mem_wdata;
  logic           mem_ready;
  logic [BW-1:0]  mem_rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  beat_t exp_q[$];
  bit    stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [LW-1:0] last_fill = '0;

  line_xfer_seq u_line_xfer_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_wb_addr   (req_wb_addr),
    .req_fill_addr (req_fill_addr),
    .req_wdata     (req_wdata),
    .busy          (busy),
    .done          (done),
    .rd_line       (rd_line),
    .mem_valid     (mem_valid),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [BW-1:0] mem_f(input logic [MAW-1:0] a);
    return {{4'h0, a}, ~{4'h0, a}, {4'hA, a} ^ 32'h1234_5678, {a, 4'h5}};
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory ready generator, changes just after each rising edge
  initial begin
    mem_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (!stall_mode) mem_ready = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = lfsr[0] | lfsr[3];
      end
    end
  end

  // monitor: compares accepted beats with the expected queue
  logic           prev_stall = 1'b0;
  logic [MAW-1:0] prev_addr;
  logic [BW-1:0]  prev_wdata;
  logic           prev_we;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(mem_valid && mem_addr == prev_addr && mem_we == prev_we &&
            (!prev_we || mem_wdata == prev_wdata),
            "R7", "beat held while stalled", LW'(mem_addr), LW'(prev_addr));
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_wdata = mem_wdata;
      prev_we    = mem_we;
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected memory beat", LW'(mem_addr), '0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, e.we ? "R4" : "R5", "beat direction",
              LW'(mem_we), LW'(e.we));
          chk(mem_addr == e.addr, e.we ? "R4" : "R5", "beat address",
              LW'(mem_addr), LW'(e.addr));
          if (e.we)
            chk(mem_wdata == e.data, "R4", "write beat data",
                LW'(mem_wdata), LW'(e.data));
        end
      end
    end
  end

  // driver: push expected beats, present the request, wait for completion
  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] wb,
                        input logic [AW-1:0] fill, input logic [LW-1:0] line,
                        input bit stray);
    logic [LW-1:0] exp_line;
    int t;
    exp_line = last_fill;
    if (op[1])
      for (int k = 0; k < NB; k++)
        exp_q.push_back('{addr: {wb, 2'(k)}, we: 1'b1, data: line[k*BW +: BW]});
    if (op[0])
      for (int k = 0; k < NB; k++) begin
        exp_q.push_back('{addr: {fill, 2'(k)}, we: 1'b0, data: '0});
        exp_line[k*BW +: BW] = mem_f({fill, 2'(k)});
      end
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_wb_addr = wb; req_fill_addr = fill; req_wdata = line;
    @(posedge clk); #1;
    // R10: disturb the request inputs after the request was taken
    req_valid = 1'b0; req_wdata = ~line; req_wb_addr = ~wb; req_fill_addr = ~fill;
    @(negedge clk);
    chk(busy, "R2", "busy after take", LW'(busy), LW'(1));
    if (stray) begin
      @(posedge clk); #1;
      req_valid = 1'b1; req_op = 2'b11;
      @(posedge clk); #1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R8", "completion pulse seen", LW'(done), LW'(1));
    chk(exp_q.size() == 0, "R6", "all beats issued in order before done",
        LW'(exp_q.size()), '0);
    if (op[0]) chk(rd_line == exp_line, "R5", "assembled line", rd_line, exp_line);
    else       chk(rd_line == last_fill, "R9", "line kept over write", rd_line, last_fill);
    last_fill = exp_line;
    @(negedge clk);
    chk(!done && !busy, "R8", "single-cycle done then idle",
        LW'({done, busy}), '0);
    exp_q.delete();
  endtask

  function automatic logic [LW-1:0] mk_line(input logic [31:0] seed);
    logic [LW-1:0] l;
    for (int i = 0; i < LW / 32; i++) l[i*32 +: 32] = seed * (i + 1) ^ 32'h9E37_79B9;
    return l;
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    req_wb_addr = '0; req_fill_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && rd_line == '0, "R1", "reset outputs",
        LW'({busy, done, mem_valid}), '0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid, "R1", "idle after release", LW'({busy, mem_valid}), '0);

    do_req(2'b10, 26'h0000123, 26'h0, mk_line(32'h11), 1'b0);        // R4, R9
    do_req(2'b01, 26'h0, 26'h2ABCDEF, mk_line(32'h22), 1'b0);        // R5
    do_req(2'b11, 26'h1000001, 26'h0FFFFFF, mk_line(32'h33), 1'b0);  // R6
    do_req(2'b10, 26'h3FFFFFF, 26'h0000005, mk_line(32'h44), 1'b0);  // R9

    // R3: no-op request is not taken
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = 2'b00; req_wb_addr = 26'h55;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!busy, "R3", "no-op not taken", LW'(busy), '0);
    repeat (4) @(negedge clk);
    chk(!mem_valid && !busy, "R3", "no beats after no-op", LW'(mem_valid), '0);

    do_req(2'b11, 26'h0ABCDE0, 26'h0123450, mk_line(32'h55), 1'b1);  // R2 stray

    stall_mode = 1'b1;                                               // R7
    do_req(2'b01, 26'h0, 26'h1357913, mk_line(32'h66), 1'b0);
    do_req(2'b11, 26'h2468ACE, 26'h0FEDCBA, mk_line(32'h77), 1'b1);
    do_req(2'b10, 26'h0000777, 26'h0, mk_line(32'h88), 1'b0);
    stall_mode = 1'b0;

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual no completion expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule